// File: doc/BRIEF.md
# Oscillator Tuning Word Encoder with Sub-Unit Dithering

This block turns a fixed-point frequency control word into the switch enables of a digitally controlled oscillator. The oscillator has three element groups. One group has elements weighted in powers of two. One group has identical unit elements. The last is a single extra unit element. The integer part of the word is split into a coarse field and a fine field. The coarse field drives the power-of-two group bit for bit. The fine field is turned into a thermometer code, so that each increment switches in exactly one more unit element and the frequency step stays monotonic.

The fractional bits feed a first-order error-feedback accumulator that is clocked far faster than the word changes. Its carry-out switches the extra unit element on for one clock. The long-run density of those pulses equals the fractional value, which gives an average tuning resolution finer than one unit element. A loop filter presents a word and pulses the valid strobe. Between updates the enables hold, and only the dither pulse stream keeps moving.

Top module: `dco_tune_encoder`

## Requirements
- R1: The tuning word is 16 bits. Bits [15:12] are the coarse field, bits [11:6] the fine field and bits [5:0] the fraction. One clock after an edge with `tuneValid` high, `coarseEn` equals the coarse field of the word sampled at that edge.
- R2: On that same edge, `fineEn` becomes a thermometer code. For a fine value k, bits [k-1:0] are set and all higher bits are clear.
- R3: Raising the fine value by one switches on exactly one more fine element, and no element that was on switches off.
- R4: While `tuneValid` is low, `coarseEn` and `fineEn` hold their values, whatever `tuneWord` carries.
- R5: Reset clears `coarseEn`, `fineEn`, `ditherEn`, the held fraction and the accumulator.
- R6: A fraction of zero keeps `ditherEn` low on every cycle.
- R7: Once a fraction f has been held for two cycles after loading, any 64 consecutive cycles contain exactly f cycles with `ditherEn` high.
- R8: A fraction of 63 gives exactly one low cycle of `ditherEn` in every 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dither-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| tuneWord | input | 16 | Fixed-point tuning word: coarse, fine, fraction |
| tuneValid | input | 1 | Load strobe for tuneWord |
| coarseEn | output | 4 | Enables for the binary-weighted elements |
| fineEn | output | 63 | Thermometer enables for the unit elements |
| ditherEn | output | 1 | Enable for the dithered extra unit element |

## Verification
The pulse-density property is the hardest case to bring about from the ports. It depends on the hidden accumulator phase, and it holds only over a whole window of cycles, never on any single cycle. The bench loads each fraction, lets two cycles pass so that the new fraction reaches the output register, and then counts `ditherEn` over 64 cycles. Because a first-order accumulator repeats with a period of 64, that count must equal the fraction for any starting phase. The extremes 0 and 63 are run over two full periods.

// File: rtl/dco_enc_pkg.sv
package dco_enc_pkg;
  localparam int COARSE_W_DEF = 4;
  localparam int FINE_W_DEF   = 6;
  localparam int FRAC_W_DEF   = 6;

  typedef struct packed {
    logic loadWord;
    logic ditherStep;
  } ctrl_strobes_t;
endpackage

// File: rtl/dco_enc_ctrl.sv
module dco_enc_ctrl
  import dco_enc_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          tuneValid,
  output ctrl_strobes_t strobes
);
  logic runEn;

  // Accumulation starts on the first clock after reset is released.
  always_ff @(posedge clk) begin
    if (rst) runEn <= 1'b0;
    else     runEn <= 1'b1;
  end

  always_comb begin
    strobes.loadWord   = tuneValid & ~rst;
    strobes.ditherStep = runEn;
  end
endmodule

// File: rtl/dco_enc_datapath.sv
module dco_enc_datapath
  import dco_enc_pkg::*;
#(
  parameter int COARSE_W = COARSE_W_DEF,
  parameter int FINE_W   = FINE_W_DEF,
  parameter int FRAC_W   = FRAC_W_DEF,
  localparam int WORD_W  = COARSE_W + FINE_W + FRAC_W,
  localparam int THERM_W = (1 << FINE_W) - 1
) (
  input  logic                clk,
  input  logic                rst,
  input  ctrl_strobes_t       strobes,
  input  logic [WORD_W-1:0]   word,
  output logic [COARSE_W-1:0] coarseEn,
  output logic [THERM_W-1:0]  fineEn,
  output logic                ditherEn
);
  logic [COARSE_W-1:0] coarseField;
  logic [FINE_W-1:0]   fineField;
  logic [FRAC_W-1:0]   fracField;
  logic [THERM_W-1:0]  thermNext;
  logic [FRAC_W-1:0]   fracReg;
  logic [FRAC_W-1:0]   acc;
  logic [FRAC_W:0]     accSum;

  assign coarseField = word[WORD_W-1 -: COARSE_W];
  assign fineField   = word[FRAC_W +: FINE_W];
  assign fracField   = word[FRAC_W-1:0];

  // Thermometer encoder: one comparator per unit element.
  for (genvar i = 0; i < THERM_W; i++) begin : g_therm
    assign thermNext[i] = ({1'b0, fineField} > (FINE_W+1)'(i));
  end

  assign accSum = {1'b0, acc} + {1'b0, fracReg};

  always_ff @(posedge clk) begin
    if (rst) begin
      coarseEn <= '0;
      fineEn   <= '0;
      fracReg  <= '0;
      acc      <= '0;
      ditherEn <= 1'b0;
    end else begin
      if (strobes.loadWord) begin
        coarseEn <= coarseField;
        fineEn   <= thermNext;
        fracReg  <= fracField;
      end
      if (strobes.ditherStep) begin
        acc      <= accSum[FRAC_W-1:0];
        ditherEn <= accSum[FRAC_W];
      end
    end
  end

  assert_coarse_load_R1: assert property (@(posedge clk) disable iff (rst)
    strobes.loadWord |=> coarseEn == $past(coarseField));

  assert_fine_count_R2: assert property (@(posedge clk) disable iff (rst)
    strobes.loadWord |=> $countones(fineEn) == int'($past(fineField)));

  assert_therm_shape_R3: assert property (@(posedge clk) disable iff (rst)
    (fineEn & (fineEn + THERM_W'(1))) == '0);

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !strobes.loadWord |=> $stable(coarseEn) && $stable(fineEn));

  assert_zero_frac_R6: assert property (@(posedge clk) disable iff (rst)
    (fracReg == '0) |=> !ditherEn);
endmodule

// File: rtl/dco_tune_encoder.sv
module dco_tune_encoder
  import dco_enc_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [15:0] tuneWord,
  input  logic        tuneValid,
  output logic [3:0]  coarseEn,
  output logic [62:0] fineEn,
  output logic        ditherEn
);
  ctrl_strobes_t strobes;

  dco_enc_ctrl ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .tuneValid (tuneValid),
    .strobes   (strobes)
  );

  dco_enc_datapath #(
    .COARSE_W (4),
    .FINE_W   (6),
    .FRAC_W   (6)
  ) dp_i (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .word     (tuneWord),
    .coarseEn (coarseEn),
    .fineEn   (fineEn),
    .ditherEn (ditherEn)
  );
endmodule

// File: tb/dco_tune_encoder_tb_top.sv
`timescale 1ns/1ps
module dco_tune_encoder_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] tuneWord = '0;
  logic        tuneValid = 1'b0;
  logic [3:0]  coarseEn;
  logic [62:0] fineEn;
  logic        ditherEn;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  dco_tune_encoder dut_i (
    .clk(clk), .rst(rst), .tuneWord(tuneWord), .tuneValid(tuneValid),
    .coarseEn(coarseEn), .fineEn(fineEn), .ditherEn(ditherEn)
  );

  localparam logic [15:0] VEC [8] = '{
    16'h0000, 16'hF03F, 16'h1FC0, 16'hA560,
    16'h5A95, 16'h7FFF, 16'h8001, 16'h3C20
  };

  function automatic logic [62:0] thermOf(input int k);
    logic [62:0] t = '0;
    for (int i = 0; i < k; i++) t[i] = 1'b1;
    return t;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic loadWord(input logic [15:0] w);
    @(negedge clk); tuneWord = w; tuneValid = 1'b1;
    @(negedge clk); tuneValid = 1'b0;
  endtask

  task automatic countDither(input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (ditherEn) cnt++;
    end
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int cnt;
    logic [3:0]  holdC;
    logic [62:0] holdF;
    repeat (3) @(negedge clk);
    // R5: reset state
    check("R5 coarse", coarseEn, 0);
    check("R5 fine", fineEn, 0);
    check("R5 dither", ditherEn, 0);
    rst = 1'b0;
    countDither(16, cnt);
    check("R5 R6 dither after reset", cnt, 0);

    foreach (VEC[v]) begin
      loadWord(VEC[v]);
      check("R1 coarse", coarseEn, VEC[v][15:12]);
      check("R2 fine", fineEn, thermOf(int'(VEC[v][11:6])));
      @(negedge clk);
      countDither(64, cnt);
      check("R7 density", cnt, VEC[v][5:0]);
    end

    // R4: word changes without valid
    loadWord(16'h6B2A);
    holdC = coarseEn; holdF = fineEn;
    @(negedge clk); tuneWord = 16'h9FFF;
    repeat (5) @(negedge clk);
    check("R4 coarse hold", coarseEn, holdC);
    check("R4 fine hold", fineEn, holdF);
    @(negedge clk);
    countDither(64, cnt);
    check("R4 frac hold", cnt, 16'h6B2A & 16'h3F);

    // R3: fine steps one element at a time
    for (int k = 0; k < 63; k++) begin
      loadWord(16'((k << 6)));
      holdF = fineEn;
      loadWord(16'(((k + 1) << 6)));
      check("R3 one more", $countones(fineEn), $countones(holdF) + 1);
      check("R3 none off", (holdF & ~fineEn), 0);
    end

    // R6: zero fraction over two periods
    loadWord(16'h4440);
    @(negedge clk);
    countDither(128, cnt);
    check("R6 zero frac", cnt, 0);

    // R8: full fraction, one low per 64
    loadWord(16'h003F);
    @(negedge clk);
    countDither(64, cnt);
    check("R8 first period", cnt, 63);
    countDither(64, cnt);
    check("R8 second period", cnt, 63);

    // R5: mid-run reset
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check("R5 coarse mid", coarseEn, 0);
    check("R5 fine mid", fineEn, 0);
    rst = 1'b0;
    countDither(64, cnt);
    check("R5 frac cleared", cnt, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule